// File: doc/BRIEF.md
# Masked Multi-Stride Stream Address Generator

This block produces one memory address per clock cycle for a single data stream walked by a nest of five hardware loops. Each loop level has its own signed stride. On every cycle the block works out which loop level is about to advance and adds that level's stride to the current address. It uses two inputs for this choice: flags that show which of the four inner levels sit at their last iteration, and a per-stream mask.

A processing engine uses four copies of the block: three for input streams and one for the output stream. Every copy takes the same last-value flags from one shared set of loop comparators. Each copy has its own base address, strides and mask. A start pulse loads the base address. A hold input freezes the address during a stall or an exception, so the address register is the only state that has to be kept.

Top module: `stride_addr_gen`

## Requirements
- R1: While reset is active, and in the first cycle after it, the address output is zero.
- R2: A start pulse loads the base address into the address register on that clock edge. Start takes priority over hold. The first stride is added on the cycle after the load.
- R3: When hold is high and start is low, the address does not change.
- R4: When no level is selected, the stride of the innermost level (level 5, bits [159:128] of the stride bus) is added.
- R5: Level k (1 to 4) is selected only when mask bit k-1 is set and the last-value flags of all deeper levels k+1 through 5 are set. Last-value flag bit j-2 belongs to level j. Any missing flag or mask bit removes level k from the choice.
- R6: When several levels are selected, the outermost one wins (the lowest level number).
- R7: Strides are two's-complement, so a negative stride lowers the address.
- R8: The address wraps modulo 2^32 and has no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load the base address |
| hold_i | input | 1 | Freeze the address (stall or exception) |
| base_i | input | 32 | Start address of the stream |
| strides_i | input | 160 | Five signed strides; level L uses bits [32L-1:32L-32] |
| mask_i | input | 4 | Bit k-1 enables the stride of level k (1 to 4) |
| last_i | input | 4 | Bit j-2 is set when level j (2 to 5) is at its last value |
| addr_o | output | 32 | Current stream address |

## Verification
The bench drives random masks and last-value flags and biases the flags toward all-ones. In that state deep levels can be selected, so the bench can tell the priority rule apart from a simple mask lookup. Directed cases then cover the remaining choices one at a time:
- only the default stride applies;
- every level is selected at once, which exposes a wrong priority order;
- a single mask bit is set while one deeper flag is missing, which exposes a mask check that skips the inner flags;
- a negative stride and a stride that crosses 2^32 are added, which catch unsigned or truncated arithmetic.

Start-under-hold and hold-only cycles are mixed in to separate the priority of loading from the priority of freezing.

// File: rtl/stride_addr_gen.sv
module stride_addr_gen #(
  parameter int AW   = 32,
  parameter int NLVL = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                hold_i,
  input  logic [AW-1:0]       base_i,
  input  logic [NLVL*AW-1:0]  strides_i,
  input  logic [NLVL-2:0]     mask_i,
  input  logic [NLVL-2:0]     last_i,
  output logic [AW-1:0]       addr_o
);

  localparam int NFLG = NLVL - 1;

  logic [NFLG-1:0] deep_last;
  logic [NFLG-1:0] sel_flag;
  logic [NLVL-1:0] pick;
  logic [NLVL:0]   taken;
  logic [AW-1:0]   step;
  logic [AW-1:0]   addr_q;

  assign deep_last[NFLG-1] = last_i[NFLG-1];
  for (genvar i = 0; i < NFLG - 1; i++) begin : g_deep
    assign deep_last[i] = last_i[i] & deep_last[i+1];
  end

  assign sel_flag = deep_last & mask_i;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < NFLG; i++) begin : g_prio
    assign pick[i]    = sel_flag[i] & ~taken[i];
    assign taken[i+1] = taken[i] | sel_flag[i];
  end
  assign pick[NLVL-1] = ~taken[NFLG];
  assign taken[NLVL]  = 1'b1;

  always_comb begin
    step = '0;
    for (int i = 0; i < NLVL; i++)
      if (pick[i]) step = strides_i[i*AW +: AW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          addr_q <= '0;
    else if (start_i)    addr_q <= base_i;
    else if (!hold_i)    addr_q <= addr_q + step;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/stride_addr_gen_chk.sv
module stride_addr_gen_chk #(
  parameter int AW   = 32,
  parameter int NLVL = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               hold_i,
  input logic [AW-1:0]      base_i,
  input logic [NLVL*AW-1:0] strides_i,
  input logic [NLVL-2:0]    mask_i,
  input logic [NLVL-2:0]    last_i,
  input logic [AW-1:0]      addr_o
);

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && start_i |=> addr_o == $past(base_i)); // R2

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !start_i && hold_i |=> addr_o == $past(addr_o)); // R3

  AST_DEFAULT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !start_i && !hold_i && !last_i[NLVL-2]
    |=> addr_o == $past(addr_o) + $past(strides_i[(NLVL-1)*AW +: AW])); // R4

  AST_OUTER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !start_i && !hold_i && mask_i[0] && (&last_i)
    |=> addr_o == $past(addr_o) + $past(strides_i[AW-1:0])); // R6

endmodule

bind stride_addr_gen stride_addr_gen_chk #(.AW(AW), .NLVL(NLVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_i(hold_i),
  .base_i(base_i), .strides_i(strides_i), .mask_i(mask_i),
  .last_i(last_i), .addr_o(addr_o));

// File: tb/stride_addr_gen_bench.sv
module stride_addr_gen_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, hold_i = 1'b0;
  logic [31:0]  base_i = '0;
  logic [159:0] strides_i = '0;
  logic [3:0]   mask_i = '0, last_i = '0;
  logic [31:0]  addr_o;
  logic [31:0]  exp_addr = '0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  stride_addr_gen u_stride_addr_gen (.*);

  function automatic int pick_level(logic [3:0] m, logic [3:0] l);
    for (int k = 0; k < 4; k++) begin
      logic ok = m[k];
      for (int j = k; j < 4; j++) ok = ok & l[j];
      if (ok) return k;
    end
    return 4;
  endfunction

  function automatic logic [31:0] model(logic [31:0] cur, logic st, logic hd,
      logic [31:0] b, logic [159:0] s, logic [3:0] m, logic [3:0] l);
    if (st) return b;
    if (hd) return cur;
    return cur + s[pick_level(m, l)*32 +: 32];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic st, logic hd, logic [31:0] b,
      logic [159:0] s, logic [3:0] m, logic [3:0] l);
    start_i = st; hold_i = hd; base_i = b; strides_i = s; mask_i = m; last_i = l;
    exp_addr = model(exp_addr, st, hd, b, s, m, l);
    @(negedge clk);
    check(tag, addr_o, exp_addr);
  endtask

  function automatic string classify(logic st, logic hd, logic [3:0] m, logic [3:0] l);
    if (st) return "R2";
    if (hd) return "R3";
    if (pick_level(m, l) == 4) return "R4";
    return "R5";
  endfunction

  initial begin
    logic [159:0] s_pos;
    logic [159:0] s_neg;
    s_pos = {32'd4, 32'h100, 32'h1000, 32'h10000, 32'h100000};
    s_neg = {-32'sd8, 32'h100, 32'h1000, 32'h10000, 32'h100000};
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", addr_o, 32'h0);
    rst_n = 1'b1;
    step("R1", 1'b0, 1'b1, 32'h0, s_pos, 4'h0, 4'h0);
    step("R2", 1'b1, 1'b1, 32'h1000, s_pos, 4'hF, 4'hF);
    step("R3", 1'b0, 1'b1, 32'h0, s_pos, 4'hF, 4'hF);
    step("R4", 1'b0, 1'b0, 32'h0, s_pos, 4'h0, 4'h0);
    step("R6", 1'b0, 1'b0, 32'h0, s_pos, 4'hF, 4'hF);
    step("R5", 1'b0, 1'b0, 32'h0, s_pos, 4'b0010, 4'b1110);
    step("R5", 1'b0, 1'b0, 32'h0, s_pos, 4'b1000, 4'b0111);
    step("R5", 1'b0, 1'b0, 32'h0, s_pos, 4'b0001, 4'b1101);
    step("R7", 1'b0, 1'b0, 32'h0, s_neg, 4'h0, 4'h0);
    step("R7", 1'b0, 1'b0, 32'h0, s_neg, 4'h0, 4'h0);
    step("R2", 1'b1, 1'b0, 32'hFFFF_FFF8, s_pos, 4'h0, 4'h0);
    step("R8", 1'b0, 1'b0, 32'h0, {32'h10, 128'h0}, 4'h0, 4'h0);
    for (int n = 0; n < 3000; n++) begin
      logic st, hd;
      logic [3:0] m, l;
      logic [159:0] s;
      st = ($urandom % 16) == 0;
      hd = ($urandom % 6) == 0;
      m = 4'($urandom);
      l = 4'($urandom) | (($urandom % 2) ? 4'hF : 4'h0);
      s = {$urandom, $urandom, $urandom, $urandom, $urandom};
      step(classify(st, hd, m, l), st, hd, $urandom, s, m, l);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule